// File: doc/BRIEF.md
# Mirrored Thread-Context Control Registers

This block holds the system-control registers of a multithreaded core whose fields overlap between registers. There is one per-core mode register, one per-core virtual-address-high register and one context-status register for each hardware thread context. The coprocessor-enable group, the DSP-enable bit and the privilege-mode field exist in both the mode register and every context-status register. The address-space identifier (ASID) sits in the low byte of both the address-high register and the context-status registers. Any write to one copy updates the other copies in the same clock edge, so a read in the following cycle sees coherent values.

Each write or read is either local or remote. A local access goes to the context given by the `cur_ctx` input. A remote access goes to the context named by the target-select register. The core-wide registers are shared, so the context index only picks which context-status entry takes part in the mirroring. The `mt_en` input enables mirroring on mode and address-high writes. The read port is combinational from the registers.

Top module: `mreg_mirror_top`

## Requirements
- R1: After synchronous active-low reset, every register reads as zero.
- R2: Register select codes are 0 = mode, 1 = address-high, 2 = context-status, 3 = target-select. A local write stores `wr_data` unchanged, and a read in the next cycle returns it.
- R3: A mode write with `mt_en` high changes the selected context-status entry as follows:
  - bits 31:28 take mode bits 31:28;
  - bit 27 takes mode bit 24;
  - bits 12:11 take mode bits 4:3;
  - bits 7:0 take address-high bits 7:0;
  - all other bits are left unchanged.
- R4: A context-status write stores `wr_data` in the selected entry. It also copies bits 31:28, 27 and 12:11 into mode bits 31:28, 24 and 4:3 respectively, and leaves the other mode bits unchanged.
- R5: A context-status write copies `wr_data[7:0]` into address-high bits 7:0 and leaves address-high bits 31:8 unchanged.
- R6: An address-high write stores `wr_data`. With `mt_en` high, it also copies `wr_data[7:0]` into bits 7:0 of the selected context-status entry and leaves that entry's other bits unchanged.
- R7: With `mt_en` low, mode and address-high writes leave every context-status entry unchanged.
- R8: The target-select register holds an 8-bit index in bits 7:0 and reads back zero-extended. Remote accesses use that index, and local accesses use `cur_ctx`.
- R9: A remote mode write forces `wr_data` bits 31:28, 24 and 4:3 to zero before storing it, and the mirror then copies those zeros.
- R10: A remote access whose target index is not below the context count is dropped. For writes, no register changes. For reads, the result is zero. Accesses to the target-select register are never dropped.
- R11: A write addressed to one context never changes the context-status entry of any other context.
- R12: When the target index equals `cur_ctx`, local and remote accesses reach the same context-status entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mt_en | input | 1 | Enables mirroring on mode and address-high writes |
| cur_ctx | input | IDX_W (2) | Index of the currently running context |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_remote | input | 1 | Write goes to the target-selected context |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_remote | input | 1 | Read goes to the target-selected context |
| rd_data | output | 32 | Read data, combinational |

## Verification
Several behaviours are checked by assertions on every cycle:
- a context-status write lands in the mode and address-high mirror fields;
- a masked update keeps the bits outside its mask;
- only one context entry is written per cycle;
- a remote mode write leaves the shared fields cleared;
- a dropped write changes nothing.

Other behaviours can only be shown by the bench's directed scenarios, since each needs a particular sequence of accesses:
- which context a remote access reaches;
- the gating by `mt_en`;
- the equivalence of local and remote access when the indices match;
- the zero read on an out-of-range target.

// File: rtl/mreg_pkg.sv
// Package: register select codes, field positions and mirror mapping
// functions shared by the mirrored register group.
// Assumes 32-bit registers; the field positions are fixed because the
// mirroring between registers depends on them.
package mreg_pkg;

    localparam int unsigned DW = 32;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_VAHI  = 2'd1,
        SEL_CTXST = 2'd2,
        SEL_TSEL  = 2'd3
    } reg_sel_e;

    // Mode register field positions
    localparam int MD_CU_HI  = 31;
    localparam int MD_CU_LO  = 28;
    localparam int MD_DSP    = 24;
    localparam int MD_PRV_HI = 4;
    localparam int MD_PRV_LO = 3;

    // Context-status register field positions
    localparam int CX_CU_HI  = 31;
    localparam int CX_CU_LO  = 28;
    localparam int CX_DSP    = 27;
    localparam int CX_PRV_HI = 12;
    localparam int CX_PRV_LO = 11;
    localparam int ASID_W    = 8;

    localparam logic [DW-1:0] MODE_SHARED = 32'hF100_0018;
    localparam logic [DW-1:0] CTX_SHARED  = 32'hF800_1800;
    localparam logic [DW-1:0] ASID_MASK   = 32'h0000_00FF;

    // Place mode-register shared fields at their context-status positions.
    function automatic logic [DW-1:0] ctx_from_mode(input logic [DW-1:0] m);
        logic [DW-1:0] r;
        r = '0;
        r[CX_CU_HI:CX_CU_LO]   = m[MD_CU_HI:MD_CU_LO];
        r[CX_DSP]              = m[MD_DSP];
        r[CX_PRV_HI:CX_PRV_LO] = m[MD_PRV_HI:MD_PRV_LO];
        return r;
    endfunction

    // Place context-status shared fields at their mode-register positions.
    function automatic logic [DW-1:0] mode_from_ctx(input logic [DW-1:0] c);
        logic [DW-1:0] r;
        r = '0;
        r[MD_CU_HI:MD_CU_LO]   = c[CX_CU_HI:CX_CU_LO];
        r[MD_DSP]              = c[CX_DSP];
        r[MD_PRV_HI:MD_PRV_LO] = c[CX_PRV_HI:CX_PRV_LO];
        return r;
    endfunction

endpackage

// File: rtl/mreg_ctx_sel.sv
// Module: resolves which context an access addresses.
// Local accesses use the current context, remote ones use the target-select
// field. Flags whether the resulting index is below the context count.
// Assumes TSEL_W bits are enough to hold any index the software may write.
module mreg_ctx_sel #(
    parameter int N_CTX  = 4,
    parameter int TSEL_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              remote,
    input  logic [IDX_W-1:0]  cur_ctx,
    input  logic [TSEL_W-1:0] tsel,
    output logic [IDX_W-1:0]  idx,
    output logic              ok
);
    localparam logic [31:0] N_LIM = N_CTX;

    // Pick the index source and range-check it.
    always_comb begin
        if (remote) begin
            idx = IDX_W'(tsel);
            ok  = (32'(tsel) < N_LIM);
        end else begin
            idx = cur_ctx;
            ok  = (32'(cur_ctx) < N_LIM);
        end
    end

    // An accepted index never exceeds the context array
    always_comb begin
        if (ok) begin
            assert_idx_range_R10: assert (32'(idx) < N_LIM);
        end
    end

endmodule

// File: rtl/mreg_masked_reg.sv
// Module: register with a per-bit write mask.
// On a write, only the bits set in the mask take the new value and the
// remaining bits hold. Reset clears the whole register.
module mreg_masked_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] wval,
    output logic [W-1:0] q
);
    // Masked update with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= (q & ~wmask) | (wval & wmask);
        end
    end

    // Bits outside the mask hold across a write
    assert_mask_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((q & ~$past(wmask)) == ($past(q) & ~$past(wmask))));

endmodule

// File: rtl/mreg_ctx_file.sv
// Module: array of per-context status registers.
// One masked write port (entry index, mask, value) and one combinational
// read port. An index outside the array writes nothing and reads zero.
module mreg_ctx_file #(
    parameter int N_CTX = 4,
    parameter int IDX_W = 2,
    parameter int W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wmask,
    input  logic [W-1:0]     wval,
    input  logic [IDX_W-1:0] ridx,
    output logic [W-1:0]     rval
);
    logic [N_CTX-1:0] ent_we;
    logic [W-1:0]     ent_q [N_CTX];

    for (genvar i = 0; i < N_CTX; i++) begin : g_ent
        // Entry write decode
        assign ent_we[i] = we && (widx == IDX_W'(i));

        mreg_masked_reg #(.W(W)) u_ent (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (ent_we[i]),
            .wmask (wmask),
            .wval  (wval),
            .q     (ent_q[i])
        );
    end

    // Read mux over all entries; no match yields zero
    always_comb begin
        rval = '0;
        for (int i = 0; i < N_CTX; i++) begin
            if (ridx == IDX_W'(i)) rval = ent_q[i];
        end
    end

    // At most one context entry changes per write
    assert_one_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ent_we));

endmodule

// File: rtl/mreg_mirror_top.sv
// Module: mirrored control register group.
// Holds the shared mode register, the address-high register, the target-
// select register and the context-status array. It keeps the shared fields
// coherent: every mirror update lands on the same edge as the write.
// Assumes a single write per cycle and a combinational read port.
module mreg_mirror_top
    import mreg_pkg::*;
#(
    parameter int N_CTX  = 4,
    parameter int TSEL_W = 8,
    localparam int IDX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mt_en,
    input  logic [IDX_W-1:0] cur_ctx,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic             wr_remote,
    input  logic [DW-1:0]    wr_data,
    input  logic [1:0]       rd_sel,
    input  logic             rd_remote,
    output logic [DW-1:0]    rd_data
);
    reg_sel_e          wsel, rsel;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic              wr_ok, rd_ok;
    logic [DW-1:0]     mode_q, ahi_q, ctx_rval;
    logic [TSEL_W-1:0] tsel_q;

    logic              mode_go, ahi_go, ctx_go, tsel_go, wr_drop, rd_bad;
    logic [DW-1:0]     mode_wval;
    logic              mode_we, ahi_we, c_we;
    logic [DW-1:0]     mode_mask, mode_val, ahi_mask, c_mask, c_val;

    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    mreg_ctx_sel #(.N_CTX(N_CTX), .TSEL_W(TSEL_W), .IDX_W(IDX_W)) u_wsel (
        .remote  (wr_remote),
        .cur_ctx (cur_ctx),
        .tsel    (tsel_q),
        .idx     (wr_idx),
        .ok      (wr_ok)
    );

    mreg_ctx_sel #(.N_CTX(N_CTX), .TSEL_W(TSEL_W), .IDX_W(IDX_W)) u_rsel (
        .remote  (rd_remote),
        .cur_ctx (cur_ctx),
        .tsel    (tsel_q),
        .idx     (rd_idx),
        .ok      (rd_ok)
    );

    // Classify the write and decide whether it is accepted
    always_comb begin
        mode_go = wr_en && wr_ok && (wsel == SEL_MODE);
        ahi_go  = wr_en && wr_ok && (wsel == SEL_VAHI);
        ctx_go  = wr_en && wr_ok && (wsel == SEL_CTXST);
        tsel_go = wr_en && (wsel == SEL_TSEL);
        wr_drop = wr_en && !wr_ok && (wsel != SEL_TSEL);
        rd_bad  = !rd_ok && (rsel != SEL_TSEL);
        mode_wval = wr_remote ? (wr_data & ~MODE_SHARED) : wr_data;
    end

    // Mode register update: direct write or mirror from a context write
    always_comb begin
        mode_we   = mode_go || ctx_go;
        mode_mask = mode_go ? '1 : MODE_SHARED;
        mode_val  = mode_go ? mode_wval : mode_from_ctx(wr_data);
    end

    // Address-high update: full write, or ASID byte from a context write
    always_comb begin
        ahi_we   = ahi_go || ctx_go;
        ahi_mask = ahi_go ? '1 : ASID_MASK;
    end

    // Context entry update: direct write or mirror from mode/address-high
    always_comb begin
        c_we   = ctx_go || (mt_en && (mode_go || ahi_go));
        c_mask = '1;
        c_val  = wr_data;
        if (!ctx_go && mode_go) begin
            c_mask = CTX_SHARED | ASID_MASK;
            c_val  = ctx_from_mode(mode_wval) | {{(DW-ASID_W){1'b0}}, ahi_q[ASID_W-1:0]};
        end else if (!ctx_go && ahi_go) begin
            c_mask = ASID_MASK;
            c_val  = wr_data;
        end
    end

    mreg_masked_reg #(.W(DW)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mode_we),
        .wmask (mode_mask),
        .wval  (mode_val),
        .q     (mode_q)
    );

    mreg_masked_reg #(.W(DW)) u_ahi (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ahi_we),
        .wmask (ahi_mask),
        .wval  (wr_data),
        .q     (ahi_q)
    );

    mreg_masked_reg #(.W(TSEL_W)) u_tsel (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tsel_go),
        .wmask ({TSEL_W{1'b1}}),
        .wval  (wr_data[TSEL_W-1:0]),
        .q     (tsel_q)
    );

    mreg_ctx_file #(.N_CTX(N_CTX), .IDX_W(IDX_W), .W(DW)) u_ctx (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (c_we),
        .widx  (wr_idx),
        .wmask (c_mask),
        .wval  (c_val),
        .ridx  (rd_idx),
        .rval  (ctx_rval)
    );

    // Read mux; a dropped remote read returns zero
    always_comb begin
        unique case (rsel)
            SEL_MODE:  rd_data = mode_q;
            SEL_VAHI:  rd_data = ahi_q;
            SEL_CTXST: rd_data = ctx_rval;
            default:   rd_data = {{(DW-TSEL_W){1'b0}}, tsel_q};
        endcase
        if (rd_bad) rd_data = '0;
    end

    // Context write lands in the mode register's shared fields
    assert_ctx_to_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_go |=> (mode_q[MD_CU_HI:MD_CU_LO] == $past(wr_data[CX_CU_HI:CX_CU_LO])
                    && mode_q[MD_DSP] == $past(wr_data[CX_DSP])
                    && mode_q[MD_PRV_HI:MD_PRV_LO] == $past(wr_data[CX_PRV_HI:CX_PRV_LO])));

    // Context write lands in the address-high ASID byte only
    assert_ctx_to_ahi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_go |=> (ahi_q[7:0] == $past(wr_data[7:0])
                    && ahi_q[DW-1:8] == $past(ahi_q[DW-1:8])));

    // Remote mode write leaves the shared fields cleared
    assert_remote_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_go && wr_remote) |=> ((mode_q & MODE_SHARED) == '0));

    // Dropped write changes no core-wide register
    assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |=> (mode_q == $past(mode_q) && ahi_q == $past(ahi_q)
                     && tsel_q == $past(tsel_q)));

endmodule

// File: tb/test_mreg_mirror_top.sv
// Directed bench: one task per scenario, each checking its own results.
module test_mreg_mirror_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] S_MODE = 2'd0, S_AHI = 2'd1, S_CTX = 2'd2, S_TSEL = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mt_en;
    logic [1:0]  cur_ctx;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic        wr_remote;
    logic [31:0] wr_data;
    logic [1:0]  rd_sel;
    logic        rd_remote;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    mreg_mirror_top i_mreg_mirror_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .mt_en     (mt_en),
        .cur_ctx   (cur_ctx),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_remote (wr_remote),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_remote (rd_remote),
        .rd_data   (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic do_wr(input logic [1:0] s, input logic rem, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_remote = rem; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] s, input logic rem,
                          input logic [31:0] exp);
        rd_sel = s; rd_remote = rem;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, rd_data, exp);
        end
    endtask

    task automatic t_reset;
        rd_chk("R1 mode", S_MODE, 1'b0, 32'h0);
        rd_chk("R1 vahi", S_AHI, 1'b0, 32'h0);
        rd_chk("R1 ctx", S_CTX, 1'b0, 32'h0);
        rd_chk("R1 tsel", S_TSEL, 1'b0, 32'h0);
        rd_chk("R1 ctx remote", S_CTX, 1'b1, 32'h0);
    endtask

    task automatic t_mode_mirror;
        mt_en = 1'b1; cur_ctx = 2'd1;
        do_wr(S_CTX, 1'b0, 32'h0000_0600);
        do_wr(S_AHI, 1'b0, 32'hABCD_1234);
        rd_chk("R6 vahi store", S_AHI, 1'b0, 32'hABCD_1234);
        rd_chk("R6 asid mirror", S_CTX, 1'b0, 32'h0000_0634);
        do_wr(S_MODE, 1'b0, 32'hA100_0019);
        rd_chk("R2 mode store", S_MODE, 1'b0, 32'hA100_0019);
        rd_chk("R3 mode mirror", S_CTX, 1'b0, 32'hA800_1E34);
    endtask

    task automatic t_ctx_write;
        do_wr(S_CTX, 1'b0, 32'h5800_0855);
        rd_chk("R4 ctx store", S_CTX, 1'b0, 32'h5800_0855);
        rd_chk("R4 mode mirror", S_MODE, 1'b0, 32'h5100_0009);
        rd_chk("R5 vahi asid", S_AHI, 1'b0, 32'hABCD_1255);
        do_wr(S_TSEL, 1'b0, 32'h0000_0000);
        rd_chk("R11 ctx0 untouched", S_CTX, 1'b1, 32'h0);
        do_wr(S_TSEL, 1'b0, 32'h0000_0002);
        rd_chk("R8 tsel read", S_TSEL, 1'b0, 32'h2);
        rd_chk("R11 ctx2 untouched", S_CTX, 1'b1, 32'h0);
    endtask

    task automatic t_mt_off;
        mt_en = 1'b0;
        do_wr(S_MODE, 1'b0, 32'h3000_0000);
        rd_chk("R7 mode stored", S_MODE, 1'b0, 32'h3000_0000);
        rd_chk("R7 ctx after mode", S_CTX, 1'b0, 32'h5800_0855);
        do_wr(S_AHI, 1'b0, 32'h1111_11AA);
        rd_chk("R7 ctx after vahi", S_CTX, 1'b0, 32'h5800_0855);
        mt_en = 1'b1;
    endtask

    task automatic t_remote;
        do_wr(S_CTX, 1'b1, 32'h9000_10C3);
        rd_chk("R8 remote ctx", S_CTX, 1'b1, 32'h9000_10C3);
        rd_chk("R8 local ctx kept", S_CTX, 1'b0, 32'h5800_0855);
        rd_chk("R4 remote mode mirror", S_MODE, 1'b0, 32'h9000_0010);
        rd_chk("R5 remote vahi", S_AHI, 1'b0, 32'h1111_11C3);
        do_wr(S_AHI, 1'b1, 32'h2222_2277);
        rd_chk("R6 remote asid", S_CTX, 1'b1, 32'h9000_1077);
        rd_chk("R11 local after remote", S_CTX, 1'b0, 32'h5800_0855);
    endtask

    task automatic t_remote_mode_clear;
        do_wr(S_MODE, 1'b1, 32'hFFFF_FFFF);
        rd_chk("R9 mode cleared", S_MODE, 1'b0, 32'h0EFF_FFE7);
        rd_chk("R9 ctx mirror zero", S_CTX, 1'b1, 32'h0000_0077);
        rd_chk("R11 ctx1 kept", S_CTX, 1'b0, 32'h5800_0855);
    endtask

    task automatic t_out_of_range;
        do_wr(S_TSEL, 1'b0, 32'h0000_0005);
        rd_chk("R10 tsel stored", S_TSEL, 1'b1, 32'h5);
        do_wr(S_MODE, 1'b1, 32'h1234_5678);
        rd_chk("R10 mode kept", S_MODE, 1'b0, 32'h0EFF_FFE7);
        do_wr(S_AHI, 1'b1, 32'hDEAD_BEEF);
        rd_chk("R10 vahi kept", S_AHI, 1'b0, 32'h2222_2277);
        do_wr(S_CTX, 1'b1, 32'hFFFF_FFFF);
        rd_chk("R10 ctx1 kept", S_CTX, 1'b0, 32'h5800_0855);
        rd_chk("R10 mode kept2", S_MODE, 1'b0, 32'h0EFF_FFE7);
        rd_chk("R10 remote mode zero", S_MODE, 1'b1, 32'h0);
        rd_chk("R10 remote ctx zero", S_CTX, 1'b1, 32'h0);
    endtask

    task automatic t_same_ctx;
        cur_ctx = 2'd3;
        do_wr(S_TSEL, 1'b0, 32'h0000_0003);
        do_wr(S_CTX, 1'b1, 32'h0000_0ABC);
        rd_chk("R12 local sees remote", S_CTX, 1'b0, 32'h0000_0ABC);
        rd_chk("R4 mode after same", S_MODE, 1'b0, 32'h0EFF_FFEF);
        rd_chk("R5 vahi after same", S_AHI, 1'b0, 32'h2222_22BC);
        do_wr(S_MODE, 1'b0, 32'h2000_0000);
        rd_chk("R12 remote sees local", S_CTX, 1'b1, 32'h2000_02BC);
        rd_chk("R3 local mirror", S_CTX, 1'b0, 32'h2000_02BC);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mt_en = 1'b0; cur_ctx = 2'd0;
        wr_en = 1'b0; wr_sel = 2'd0; wr_remote = 1'b0; wr_data = '0;
        rd_sel = 2'd0; rd_remote = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_mode_mirror;
        t_ctx_write;
        t_mt_off;
        t_remote;
        t_remote_mode_clear;
        t_out_of_range;
        t_same_ctx;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule